// File: doc/BRIEF.md
# UART Buffer and Interrupt Unit

This block holds the byte buffering and event logic between a register bus and a UART serial engine. Three FIFOs live inside it. A deep receive FIFO is filled by the serial receiver and drained by host reads. A deep transmit FIFO is drained by the serial transmitter. A shallow staging FIFO takes host writes and forwards one byte per cycle into the transmit FIFO whenever there is room. Each FIFO reports its fill count and its empty and full flags.

Events are raised at the moment a push or pop happens, not from static levels. Each event sets its own sticky bit in a status vector. Software clears a bit by writing a one to it. A mask vector keeps chosen bits from reaching the single registered interrupt output. The almost-full threshold for the receive side and the almost-empty threshold for the transmit side are inputs that software programs. The serial bit engines are outside this block and are modelled as push and pop strobes with error pulses.

Top module: `uart_bufirq`

## Requirements
- R1: After reset every count is 0, every empty flag is 1, every full flag is 0, status_vec is 0 and irq is 0. Counts never exceed the FIFO depth, and a FIFO is never reported empty and full at once.
- R2: The receive FIFO returns bytes in arrival order. host_rd_data is registered and holds the popped byte from the cycle after host_rd_en. rx_count is the number of bytes held, up to 256.
- R3: A host write enters the write FIFO. The cycle after, the byte moves to the transmit FIFO if that FIFO is not full, and status bit 9 is set. ser_tx_data shows the oldest transmit byte while ser_tx_valid is 1. An accepted ser_tx_pop sets bit 7, and an accepted receive push sets bit 8.
- R4: A ser_rx_push while the receive FIFO is full discards the byte, leaves rx_count at 256 and sets status bit 4.
- R5: host_rd_en while the receive FIFO is empty sets status bit 0, loads 0 into host_rd_data and leaves rx_count unchanged.
- R6: A status bit stays set until clr_en is high with a 1 in that bit of clr_vec. A 0 in clr_vec leaves the bit unchanged.
- R7: If hardware sets a status bit in the same cycle that software clears it, the bit ends up set.
- R8: irq is 1 in the cycle after status_vec AND NOT mask_vec is non-zero, and 0 otherwise. Masked bits are still recorded in status_vec.
- R9: Status bit 5 is set when a byte is accepted into the receive FIFO while rx_count before the push is at or above rx_afull_lvl.
- R10: Status bit 11 is set when a byte is popped from the transmit FIFO while tx_count before the pop is at or below tx_aempty_lvl.
- R11: A host write while the write FIFO holds 4 bytes is dropped and sets status bit 1. wr_count is 3 bits wide and reads 4 when the FIFO is full.
- R12: ser_frame_err sets bit 2, ser_parity_err sets bit 3 and proto_rd_err sets bit 10. Bit 6 is reserved and always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host byte write strobe into the write FIFO |
| host_wr_data | input | 8 | Host write byte |
| host_rd_en | input | 1 | Host read strobe from the receive FIFO |
| host_rd_data | output | 8 | Registered read byte (0 after a read on empty) |
| ser_rx_push | input | 1 | Serial receiver delivers a byte |
| ser_rx_data | input | 8 | Received byte |
| ser_frame_err | input | 1 | Framing error pulse from the receiver |
| ser_parity_err | input | 1 | Parity error pulse from the receiver |
| ser_tx_pop | input | 1 | Serial transmitter takes the head byte |
| ser_tx_data | output | 8 | Head byte of the transmit FIFO |
| ser_tx_valid | output | 1 | Transmit FIFO holds at least one byte |
| proto_rd_err | input | 1 | Protocol-mode receive read error pulse |
| rx_afull_lvl | input | 9 | Receive almost-full threshold |
| tx_aempty_lvl | input | 9 | Transmit almost-empty threshold |
| mask_vec | input | 12 | Interrupt mask, 1 blocks the bit |
| clr_en | input | 1 | Status clear write strobe |
| clr_vec | input | 12 | Write-one-to-clear pattern |
| status_vec | output | 12 | Sticky event status |
| irq | output | 1 | Registered interrupt request |
| rx_count | output | 9 | Receive FIFO occupancy |
| tx_count | output | 9 | Transmit FIFO occupancy |
| wr_count | output | 3 | Write FIFO occupancy |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_full | output | 1 | Receive FIFO full |
| wr_empty | output | 1 | Write FIFO empty |
| wr_full | output | 1 | Write FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_full | output | 1 | Transmit FIFO full |

## Verification
The bench fills the receive FIFO to exactly 256 bytes and pushes one more. A design with an off-by-one full flag would store that byte or wrap the count, and a design without a discard would corrupt the later readback. It steps occupancy across each threshold one byte at a time. Comparing after the update instead of before, or using a strict comparison, moves the almost-full or almost-empty bit by one push or pop. It also clears a bit in the same cycle that hardware sets it, which a clear-wins design would lose. It backs the transmit FIFO up until the write FIFO fills, so that a dropped fifth write shows up both in the count and in bit 1.

// File: rtl/uart_bufirq_pkg.sv
package uart_bufirq_pkg;

    localparam int NUM_EV = 12;

    // Status bit positions; software decodes these, so the order is fixed.
    localparam int EV_RD_EMPTY  = 0;
    localparam int EV_WR_FULL   = 1;
    localparam int EV_FRAME     = 2;
    localparam int EV_PARITY    = 3;
    localparam int EV_RX_OVF    = 4;
    localparam int EV_RX_AFULL  = 5;
    localparam int EV_RSVD      = 6;
    localparam int EV_TX_POP    = 7;
    localparam int EV_RX_PUSH   = 8;
    localparam int EV_WR_POP    = 9;
    localparam int EV_PROTO     = 10;
    localparam int EV_TX_AEMPTY = 11;

    typedef logic [NUM_EV-1:0] ev_vec_t;

    typedef struct packed {
        logic full;
        logic empty;
    } fifo_flags_t;

    // Bits that hardware may ever hold in the status vector.
    function automatic ev_vec_t ev_live_mask();
        ev_vec_t m;
        m = '1;
        m[EV_RSVD] = 1'b0;
        return m;
    endfunction

endpackage

// File: rtl/ubi_fifo.sv
module ubi_fifo
    import uart_bufirq_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count,
    output fifo_flags_t      flags
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wptr_q, rptr_q;
    logic [CW-1:0]    count_q;
    logic             push_ok, pop_ok;

    assign flags.full  = (count_q == CW'(DEPTH));
    assign flags.empty = (count_q == '0);
    assign push_ok     = push && !flags.full;
    assign pop_ok      = pop && !flags.empty;

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wptr_q] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            count_q <= '0;
        end else begin
            if (push_ok) begin
                wptr_q <= wptr_q + 1'b1;
            end
            if (pop_ok) begin
                rptr_q <= rptr_q + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assign head  = mem[rptr_q];
    assign count = count_q;

endmodule

// File: rtl/ubi_event_detect.sv
module ubi_event_detect
    import uart_bufirq_pkg::*;
#(
    parameter int RX_CW = 9,
    parameter int TX_CW = 9
) (
    input  logic             host_rd_en,
    input  logic             host_wr_en,
    input  logic             ser_rx_push,
    input  logic             ser_tx_pop,
    input  logic             ser_frame_err,
    input  logic             ser_parity_err,
    input  logic             proto_rd_err,
    input  fifo_flags_t      rx_flags,
    input  fifo_flags_t      wr_flags,
    input  fifo_flags_t      tx_flags,
    input  logic [RX_CW-1:0] rx_count,
    input  logic [TX_CW-1:0] tx_count,
    input  logic [RX_CW-1:0] rx_afull_lvl,
    input  logic [TX_CW-1:0] tx_aempty_lvl,
    output logic             wr_to_tx,
    output ev_vec_t          set_vec
);

    logic rx_take, tx_give;

    // Accepted transfers only; rejected ones raise the error bits instead.
    assign rx_take  = ser_rx_push && !rx_flags.full;
    assign tx_give  = ser_tx_pop && !tx_flags.empty;
    assign wr_to_tx = !wr_flags.empty && !tx_flags.full;

    always_comb begin
        set_vec = '0;
        set_vec[EV_RD_EMPTY]  = host_rd_en && rx_flags.empty;
        set_vec[EV_WR_FULL]   = host_wr_en && wr_flags.full;
        set_vec[EV_FRAME]     = ser_frame_err;
        set_vec[EV_PARITY]    = ser_parity_err;
        set_vec[EV_RX_OVF]    = ser_rx_push && rx_flags.full;
        set_vec[EV_RX_AFULL]  = rx_take && (rx_count >= rx_afull_lvl);
        set_vec[EV_TX_POP]    = tx_give;
        set_vec[EV_RX_PUSH]   = rx_take;
        set_vec[EV_WR_POP]    = wr_to_tx;
        set_vec[EV_PROTO]     = proto_rd_err;
        set_vec[EV_TX_AEMPTY] = tx_give && (tx_count <= tx_aempty_lvl);
    end

endmodule

// File: rtl/ubi_event_reg.sv
module ubi_event_reg
    import uart_bufirq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ev_vec_t set_vec,
    input  logic    clr_en,
    input  ev_vec_t clr_vec,
    input  ev_vec_t mask_vec,
    output ev_vec_t status,
    output logic    irq
);

    ev_vec_t status_q;
    ev_vec_t clr_eff;
    logic    irq_q;

    assign clr_eff = clr_en ? clr_vec : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            // Set is ORed in after the clear, so a same-cycle set survives.
            status_q <= ((status_q & ~clr_eff) | set_vec) & ev_live_mask();
            irq_q    <= |(status_q & ~mask_vec);
        end
    end

    assign status = status_q;
    assign irq    = irq_q;

endmodule

// File: rtl/uart_bufirq.sv
module uart_bufirq
    import uart_bufirq_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int RX_DEPTH = 256,
    parameter int TX_DEPTH = 256,
    parameter int WR_DEPTH = 4,
    localparam int RX_CW = $clog2(RX_DEPTH) + 1,
    localparam int TX_CW = $clog2(TX_DEPTH) + 1,
    localparam int WR_CW = $clog2(WR_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr_en,
    input  logic [DATA_W-1:0] host_wr_data,
    input  logic              host_rd_en,
    output logic [DATA_W-1:0] host_rd_data,
    input  logic              ser_rx_push,
    input  logic [DATA_W-1:0] ser_rx_data,
    input  logic              ser_frame_err,
    input  logic              ser_parity_err,
    input  logic              ser_tx_pop,
    output logic [DATA_W-1:0] ser_tx_data,
    output logic              ser_tx_valid,
    input  logic              proto_rd_err,
    input  logic [RX_CW-1:0]  rx_afull_lvl,
    input  logic [TX_CW-1:0]  tx_aempty_lvl,
    input  logic [NUM_EV-1:0] mask_vec,
    input  logic              clr_en,
    input  logic [NUM_EV-1:0] clr_vec,
    output logic [NUM_EV-1:0] status_vec,
    output logic              irq,
    output logic [RX_CW-1:0]  rx_count,
    output logic [TX_CW-1:0]  tx_count,
    output logic [WR_CW-1:0]  wr_count,
    output logic              rx_empty,
    output logic              rx_full,
    output logic              wr_empty,
    output logic              wr_full,
    output logic              tx_empty,
    output logic              tx_full
);

    fifo_flags_t       rx_flags, wr_flags, tx_flags;
    logic [DATA_W-1:0] rx_head, wr_head;
    logic              wr_to_tx;
    ev_vec_t           set_vec;
    logic [DATA_W-1:0] rd_data_q;

    ubi_fifo #(.WIDTH(DATA_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (ser_rx_push),
        .push_data (ser_rx_data),
        .pop       (host_rd_en),
        .head      (rx_head),
        .count     (rx_count),
        .flags     (rx_flags)
    );

    ubi_fifo #(.WIDTH(DATA_W), .DEPTH(WR_DEPTH)) u_wr_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (host_wr_en),
        .push_data (host_wr_data),
        .pop       (wr_to_tx),
        .head      (wr_head),
        .count     (wr_count),
        .flags     (wr_flags)
    );

    ubi_fifo #(.WIDTH(DATA_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (wr_to_tx),
        .push_data (wr_head),
        .pop       (ser_tx_pop),
        .head      (ser_tx_data),
        .count     (tx_count),
        .flags     (tx_flags)
    );

    ubi_event_detect #(.RX_CW(RX_CW), .TX_CW(TX_CW)) u_detect (
        .host_rd_en     (host_rd_en),
        .host_wr_en     (host_wr_en),
        .ser_rx_push    (ser_rx_push),
        .ser_tx_pop     (ser_tx_pop),
        .ser_frame_err  (ser_frame_err),
        .ser_parity_err (ser_parity_err),
        .proto_rd_err   (proto_rd_err),
        .rx_flags       (rx_flags),
        .wr_flags       (wr_flags),
        .tx_flags       (tx_flags),
        .rx_count       (rx_count),
        .tx_count       (tx_count),
        .rx_afull_lvl   (rx_afull_lvl),
        .tx_aempty_lvl  (tx_aempty_lvl),
        .wr_to_tx       (wr_to_tx),
        .set_vec        (set_vec)
    );

    ubi_event_reg u_events (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (set_vec),
        .clr_en   (clr_en),
        .clr_vec  (clr_vec),
        .mask_vec (mask_vec),
        .status   (status_vec),
        .irq      (irq)
    );

    // Registered read port: an empty read returns zero.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data_q <= '0;
        end else if (host_rd_en) begin
            rd_data_q <= rx_flags.empty ? '0 : rx_head;
        end
    end

    assign host_rd_data = rd_data_q;
    assign ser_tx_valid = !tx_flags.empty;
    assign rx_empty     = rx_flags.empty;
    assign rx_full      = rx_flags.full;
    assign wr_empty     = wr_flags.empty;
    assign wr_full      = wr_flags.full;
    assign tx_empty     = tx_flags.empty;
    assign tx_full      = tx_flags.full;

endmodule

// File: rtl/uart_bufirq_chk.sv
module uart_bufirq_chk #(
    parameter int RX_DEPTH = 256,
    parameter int WR_DEPTH = 4,
    parameter int RX_CW    = 9,
    parameter int WR_CW    = 3,
    parameter int NEV      = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             host_rd_en,
    input logic [7:0]       host_rd_data,
    input logic             ser_rx_push,
    input logic             rx_full,
    input logic             rx_empty,
    input logic [RX_CW-1:0] rx_count,
    input logic [WR_CW-1:0] wr_count,
    input logic             clr_en,
    input logic [NEV-1:0]   status_vec,
    input logic [NEV-1:0]   mask_vec,
    input logic             irq
);

    // R1
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_count <= RX_CW'(RX_DEPTH)) && (wr_count <= WR_CW'(WR_DEPTH)));

    // R1
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rx_full && rx_empty));

    // R4
    rx_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (ser_rx_push && rx_full && !host_rd_en) |=> (rx_count == $past(rx_count)));

    // R5
    rd_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd_en && rx_empty) |=> (status_vec[0] && (host_rd_data == 8'h00)));

    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_en |=> ((status_vec & $past(status_vec)) == $past(status_vec)));

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((status_vec & ~mask_vec) == '0) |=> !irq);

endmodule

bind uart_bufirq uart_bufirq_chk #(
    .RX_DEPTH (RX_DEPTH),
    .WR_DEPTH (WR_DEPTH),
    .RX_CW    (RX_CW),
    .WR_CW    (WR_CW),
    .NEV      (12)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .host_rd_en   (host_rd_en),
    .host_rd_data (host_rd_data),
    .ser_rx_push  (ser_rx_push),
    .rx_full      (rx_full),
    .rx_empty     (rx_empty),
    .rx_count     (rx_count),
    .wr_count     (wr_count),
    .clr_en       (clr_en),
    .status_vec   (status_vec),
    .mask_vec     (mask_vec),
    .irq          (irq)
);

// File: tb/uart_bufirq_bench.sv
`timescale 1ns/1ps
module uart_bufirq_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_wr_en, host_rd_en, ser_rx_push, ser_frame_err, ser_parity_err;
    logic        ser_tx_pop, proto_rd_err, clr_en, ser_tx_valid, irq;
    logic [7:0]  host_wr_data, host_rd_data, ser_rx_data, ser_tx_data;
    logic [8:0]  rx_afull_lvl, tx_aempty_lvl, rx_count, tx_count;
    logic [2:0]  wr_count;
    logic [11:0] mask_vec, clr_vec, status_vec;
    logic        rx_empty, rx_full, wr_empty, wr_full, tx_empty, tx_full;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    uart_bufirq u_uart_bufirq (
        .clk(clk), .rst(rst),
        .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
        .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
        .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data),
        .ser_frame_err(ser_frame_err), .ser_parity_err(ser_parity_err),
        .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data), .ser_tx_valid(ser_tx_valid),
        .proto_rd_err(proto_rd_err),
        .rx_afull_lvl(rx_afull_lvl), .tx_aempty_lvl(tx_aempty_lvl),
        .mask_vec(mask_vec), .clr_en(clr_en), .clr_vec(clr_vec),
        .status_vec(status_vec), .irq(irq),
        .rx_count(rx_count), .tx_count(tx_count), .wr_count(wr_count),
        .rx_empty(rx_empty), .rx_full(rx_full), .wr_empty(wr_empty),
        .wr_full(wr_full), .tx_empty(tx_empty), .tx_full(tx_full)
    );

    // Receive-path vectors: [17]=1 read / 0 push, [16:9]=byte pushed or
    // byte expected back, [8:0]=rx_count expected afterwards.
    localparam logic [17:0] RXV [8] = '{
        {1'b0, 8'hA1, 9'd1},
        {1'b0, 8'hB2, 9'd2},
        {1'b0, 8'hC3, 9'd3},
        {1'b1, 8'hA1, 9'd2},
        {1'b0, 8'hD4, 9'd3},
        {1'b1, 8'hB2, 9'd2},
        {1'b1, 8'hC3, 9'd1},
        {1'b1, 8'hD4, 9'd0}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_all();
        clr_en = 1'b1; clr_vec = 12'hFFF;
        tick();
        clr_en = 1'b0; clr_vec = 12'h000;
    endtask

    task automatic rx_push(input logic [7:0] b);
        ser_rx_push = 1'b1; ser_rx_data = b;
        tick();
        ser_rx_push = 1'b0;
    endtask

    task automatic rx_read();
        host_rd_en = 1'b1;
        tick();
        host_rd_en = 1'b0;
    endtask

    task automatic host_write(input logic [7:0] b);
        host_wr_en = 1'b1; host_wr_data = b;
        tick();
        host_wr_en = 1'b0;
    endtask

    task automatic tx_take();
        ser_tx_pop = 1'b1;
        tick();
        ser_tx_pop = 1'b0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int errs;
        rst = 1'b1;
        host_wr_en = 0; host_rd_en = 0; ser_rx_push = 0; ser_frame_err = 0;
        ser_parity_err = 0; ser_tx_pop = 0; proto_rd_err = 0; clr_en = 0;
        host_wr_data = 0; ser_rx_data = 0; clr_vec = 0; mask_vec = 0;
        rx_afull_lvl = 9'd256; tx_aempty_lvl = 9'd0;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        check("R1", "counts", {rx_count, tx_count, wr_count}, 0);
        check("R1", "empties", {rx_empty, wr_empty, tx_empty}, 3'b111);
        check("R1", "fulls", {rx_full, wr_full, tx_full}, 3'b000);
        check("R1", "status/irq", {status_vec, irq}, 0);

        // R2 vector walk over the receive path
        for (int i = 0; i < 8; i++) begin
            if (RXV[i][17]) begin
                rx_read();
                check("R2", "read byte", host_rd_data, RXV[i][16:9]);
            end else begin
                rx_push(RXV[i][16:9]);
            end
            check("R2", "rx_count", rx_count, RXV[i][8:0]);
        end
        check("R3", "rx push bit 8", status_vec[8], 1'b1);
        clear_all();

        // R5 read on empty
        rx_read();
        check("R5", "empty read data", host_rd_data, 8'h00);
        check("R5", "rd error bit", status_vec, 12'h001);
        check("R5", "count unchanged", rx_count, 9'd0);

        // R12 error pulses, and R6 write-one-to-clear
        ser_frame_err = 1; tick(); ser_frame_err = 0;
        check("R12", "frame bit", status_vec, 12'h005);
        clr_en = 1; clr_vec = 12'h000; tick(); clr_en = 0;
        check("R6", "zero write keeps bits", status_vec, 12'h005);
        clr_en = 1; clr_vec = 12'h004; tick(); clr_en = 0; clr_vec = 0;
        check("R6", "one write clears bit", status_vec, 12'h001);
        ser_parity_err = 1; proto_rd_err = 1; tick();
        ser_parity_err = 0; proto_rd_err = 0;
        check("R12", "parity+proto bits, bit6 zero", status_vec, 12'h409);

        // R7 set beats clear in the same cycle
        clear_all();
        ser_frame_err = 1; clr_en = 1; clr_vec = 12'hFFF; tick();
        ser_frame_err = 0; clr_en = 0; clr_vec = 0;
        check("R7", "set wins", status_vec, 12'h004);

        // R8 mask and interrupt timing
        clear_all(); tick();
        check("R8", "irq idle", irq, 1'b0);
        mask_vec = 12'hFFF;
        ser_frame_err = 1; tick(); ser_frame_err = 0;
        tick();
        check("R8", "masked bit recorded", status_vec, 12'h004);
        check("R8", "masked irq low", irq, 1'b0);
        mask_vec = 12'h000; tick();
        check("R8", "unmasked irq high", irq, 1'b1);
        clear_all(); tick();
        check("R8", "irq drops after clear", irq, 1'b0);
        ser_parity_err = 1; tick(); ser_parity_err = 0;
        check("R8", "irq lags status", {status_vec[3], irq}, 2'b10);
        tick();
        check("R8", "irq one cycle later", irq, 1'b1);

        // R9 almost-full against the pre-push count
        clear_all();
        rx_afull_lvl = 9'd3;
        for (int i = 0; i < 3; i++) rx_push(8'(i));
        check("R9", "below threshold", status_vec[5], 1'b0);
        rx_push(8'h33);
        check("R9", "at threshold", status_vec[5], 1'b1);
        for (int i = 0; i < 4; i++) rx_read();
        rx_afull_lvl = 9'd256;

        // R4 overflow
        clear_all();
        for (int i = 0; i < 256; i++) rx_push(8'(i));
        check("R4", "full count", {rx_count, rx_full}, {9'd256, 1'b1});
        check("R4", "no overflow yet", status_vec[4], 1'b0);
        rx_push(8'hEE);
        check("R4", "count held", rx_count, 9'd256);
        check("R4", "overflow bit", status_vec[4], 1'b1);
        errs = 0;
        for (int i = 0; i < 256; i++) begin
            rx_read();
            if (host_rd_data !== 8'(i)) errs++;
        end
        check("R4", "readback mismatches (byte dropped)", errs, 0);
        check("R2", "drained empty", {rx_count, rx_empty}, {9'd0, 1'b1});

        // R3 write path and transfer
        clear_all();
        host_write(8'h5A);
        check("R3", "staged in write fifo", {wr_count, tx_count}, {3'd1, 9'd0});
        tick();
        check("R3", "moved to tx", {wr_count, tx_count}, {3'd0, 9'd1});
        check("R3", "wr pop bit 9", status_vec[9], 1'b1);
        check("R3", "tx head", {ser_tx_valid, ser_tx_data}, {1'b1, 8'h5A});
        tx_take();
        check("R3", "tx pop bit 7", {status_vec[7], tx_count}, {1'b1, 9'd0});

        // R10 almost-empty against the pre-pop count
        clear_all();
        tx_aempty_lvl = 9'd1;
        host_write(8'h11); host_write(8'h22); host_write(8'h33);
        tick();
        check("R10", "tx holds three", tx_count, 9'd3);
        check("R3", "tx order 1", ser_tx_data, 8'h11);
        tx_take();
        check("R3", "tx order 2", ser_tx_data, 8'h22);
        tx_take();
        check("R10", "above threshold", status_vec[11], 1'b0);
        check("R3", "tx order 3", ser_tx_data, 8'h33);
        tx_take();
        check("R10", "at threshold", status_vec[11], 1'b1);
        tx_aempty_lvl = 9'd0;

        // R11 write fifo full when tx is backed up
        clear_all();
        for (int i = 0; i < 260; i++) host_write(8'(i));
        tick();
        check("R11", "both full", {tx_full, wr_full, wr_count, tx_count},
              {1'b1, 1'b1, 3'd4, 9'd256});
        check("R11", "no write error yet", status_vec[1], 1'b0);
        host_write(8'hFF);
        check("R11", "dropped write", {wr_count, status_vec[1]}, {3'd4, 1'b1});
        tx_take(); tick();
        check("R11", "drain resumes", {wr_count, tx_count}, {3'd3, 9'd256});

        finish_run();
    end

endmodule